// File: doc/BRIEF.md
# Single-Wire Frame Receiver and Demultiplexer

This block takes one serial line that carries, merged together, a frame clock, a pulse level and a stream of data words, and separates them again. It runs on the local system clock. Every frame has five slots of eight clocks each. The slots are, in order: an idle low, a start high, the pulse level, a valid flag, and one data bit. The receiver brings the line through a two-flop synchronizer and locks onto each frame from the low-to-high step into the start slot. It then samples the remaining slots at their centres, counting from that detected edge.

For each frame the receiver does four things. It drives the pulse level onto `pulse_out`. It rebuilds a 50% square wave on `fclk_out`. It gives a one-cycle trigger on `tx_trig`, half a frame after the detected start, so that a local transmitter can begin its own frame. It shifts the data bit into a word when the valid flag is set. Data words are 30 bits wide and arrive most significant bit first, one bit per valid frame. Any frame with the valid flag clear throws away a partly built word, and this is how word alignment is recovered.

A complete word goes out on a valid/ready stream. Back-pressure rule: while `word_valid` is high and `word_ready` is low, the word is held unchanged. A transfer takes place on any clock where both are high. If a new word completes while the previous one is still waiting, the new word is dropped and a sticky `overflow` flag is set.

Top module: `line_frame_rx`

## Requirements
- R1: After reset, `pulse_out`, `fclk_out`, `tx_trig`, `word_valid` and `overflow` are all 0.
- R2: The line is synchronized through two flops. A frame is detected when the line steps from 0 to 1 while the receiver is armed. A line held steady at 1 produces no further detection.
- R3: After a detection, rising edges are ignored until the data slot has been sampled, 28 clocks after detection. Each frame therefore yields exactly one `tx_trig` pulse, even when the pulse, valid or data slot makes its own rising edge.
- R4: The pulse slot is sampled 12 clocks after detection, at its centre. `pulse_out` takes that value and holds it until the next frame's sample.
- R5: `tx_trig` is high for exactly one clock, 20 clocks after detection. That is 22 clocks after the line input rises.
- R6: `fclk_out` rises 1 clock after detection (3 clocks after the line rises). It falls 20 clocks later, in the clock after `tx_trig`, and stays low until the next detection.
- R7: A frame whose valid slot (sampled 20 clocks after detection) is 1 adds its data bit (sampled 28 clocks after detection) to the word. Bits arrive MSB first. After the 30th such bit the word is presented, so bit 29 is the first bit received.
- R8: A frame whose valid slot is 0 discards any partial word. The next word starts over from bit 29.
- R9: While `word_valid` is 1 and `word_ready` is 0, `word_data` and `word_valid` hold. With both high the word is taken and `word_valid` falls in the next clock, unless a new word loads at that clock.
- R10: If a word completes while `word_valid` is 1 and `word_ready` is 0, that word is dropped, `word_data` keeps the old word, and `overflow` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Active-low reset |
| line_in | input | 1 | Multiplexed serial line (asynchronous) |
| pulse_out | output | 1 | Recovered pulse level |
| fclk_out | output | 1 | Recovered frame-rate square wave |
| tx_trig | output | 1 | One-cycle trigger for a local transmitter |
| word_data | output | 30 | Assembled data word |
| word_valid | output | 1 | Word stream valid |
| word_ready | input | 1 | Word stream ready |
| overflow | output | 1 | Sticky flag: a word was dropped |

## Verification
The bench drives frames in which the pulse, valid and data slots make extra rising edges. A receiver that re-armed too early would fire `tx_trig` twice in those frames, or slip its sample points. In each frame it times the trigger and the recovered clock against the rise of the line. An off-by-one in the counter or in the synchronizer depth shows up as a shifted offset or a 19- or 21-clock high phase. It breaks a word with an invalid frame after ten bits and expects the next word to come out intact; a design that kept the stale bits would emit a shifted word. It also completes a word while the stream is stalled. A design that overwrote the held word, lost the sticky flag, or released the word without a handshake would be caught there.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
  // Per-frame sample strobes, one clock wide each.
  typedef struct packed {
    logic pls;  // pulse slot centre
    logic vld;  // valid slot centre
    logic dat;  // data slot centre
  } lfr_strobe_t;
endpackage

// File: rtl/lfr_sync.sv
module lfr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lfr_framer.sv
module lfr_framer
  import lfr_pkg::*;
#(
  parameter int SLOT_CLKS = 8,
  parameter int SLOTS     = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_s,
  output lfr_strobe_t stb,
  output logic        fclk_out,
  output logic        tx_trig
);
  localparam int FRAME_CLKS = SLOT_CLKS * SLOTS;
  localparam int HALF       = FRAME_CLKS / 2;
  localparam int MID        = SLOT_CLKS / 2;
  // Positions counted from the detected start edge (start slot = 0).
  localparam int P_POS      = SLOT_CLKS + MID;
  localparam int V_POS      = 2 * SLOT_CLKS + MID;
  localparam int D_POS      = 3 * SLOT_CLKS + MID;
  localparam int CNT_W      = $clog2(FRAME_CLKS) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             line_d;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             fclk_q;
  logic             trig_q;
  logic             start_edge;

  assign start_edge = line_s & ~line_d & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_d <= 1'b0;
      armed  <= 1'b1;
      cnt    <= CNT_MAX;
      fclk_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      line_d <= line_s;
      trig_q <= !start_edge && (cnt == CNT_W'(HALF - 1));
      if (start_edge) begin
        cnt    <= CNT_W'(1);
        armed  <= 1'b0;
        fclk_q <= 1'b1;
      end else begin
        if (cnt != CNT_MAX)       cnt    <= cnt + CNT_W'(1);
        if (cnt == CNT_W'(D_POS)) armed  <= 1'b1;
        if (cnt == CNT_W'(HALF))  fclk_q <= 1'b0;
      end
    end
  end

  assign stb.pls = (cnt == CNT_W'(P_POS));
  assign stb.vld = (cnt == CNT_W'(V_POS));
  assign stb.dat = (cnt == CNT_W'(D_POS));
  assign fclk_out = fclk_q;
  assign tx_trig  = trig_q;
endmodule

// File: rtl/lfr_deser.sv
module lfr_deser
  import lfr_pkg::*;
#(
  parameter int WORD_BITS = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_s,
  input  lfr_strobe_t          stb,
  input  logic                 word_ready,
  output logic                 pulse_out,
  output logic [WORD_BITS-1:0] word_data,
  output logic                 word_valid,
  output logic                 overflow
);
  localparam int BCNT_W = $clog2(WORD_BITS + 1);
  localparam logic [BCNT_W-1:0] LAST = BCNT_W'(WORD_BITS - 1);

  logic                 pls_q;
  logic                 vld_q;
  logic [WORD_BITS-1:0] shreg;
  logic [BCNT_W-1:0]    bcnt;
  logic [WORD_BITS-1:0] out_q;
  logic                 out_v;
  logic                 ovf_q;
  logic                 slot_free;

  assign slot_free = !out_v || word_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pls_q <= 1'b0;
      vld_q <= 1'b0;
      shreg <= '0;
      bcnt  <= '0;
      out_q <= '0;
      out_v <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (stb.pls) pls_q <= line_s;
      if (stb.vld) vld_q <= line_s;
      if (out_v && word_ready) out_v <= 1'b0;
      if (stb.dat) begin
        if (!vld_q) begin
          bcnt <= '0;
        end else if (bcnt == LAST) begin
          bcnt <= '0;
          if (slot_free) begin
            out_q <= {shreg[WORD_BITS-2:0], line_s};
            out_v <= 1'b1;
          end else begin
            ovf_q <= 1'b1;
          end
        end else begin
          shreg <= {shreg[WORD_BITS-2:0], line_s};
          bcnt  <= bcnt + BCNT_W'(1);
        end
      end
    end
  end

  assign pulse_out  = pls_q;
  assign word_data  = out_q;
  assign word_valid = out_v;
  assign overflow   = ovf_q;
endmodule

// File: rtl/line_frame_rx.sv
module line_frame_rx
  import lfr_pkg::*;
#(
  parameter int SLOT_CLKS   = 8,
  parameter int SLOTS       = 5,
  parameter int WORD_BITS   = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_in,
  output logic                 pulse_out,
  output logic                 fclk_out,
  output logic                 tx_trig,
  output logic [WORD_BITS-1:0] word_data,
  output logic                 word_valid,
  input  logic                 word_ready,
  output logic                 overflow
);
  logic        line_s;
  lfr_strobe_t stb;

  lfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  lfr_framer #(.SLOT_CLKS(SLOT_CLKS), .SLOTS(SLOTS)) u_framer (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .stb(stb),
    .fclk_out(fclk_out), .tx_trig(tx_trig)
  );

  lfr_deser #(.WORD_BITS(WORD_BITS)) u_deser (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .stb(stb),
    .word_ready(word_ready), .pulse_out(pulse_out),
    .word_data(word_data), .word_valid(word_valid), .overflow(overflow)
  );
endmodule

// File: rtl/lfr_checker.sv
module lfr_checker #(
  parameter int WORD_BITS = 30
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pulse_out,
  input logic                 fclk_out,
  input logic                 tx_trig,
  input logic [WORD_BITS-1:0] word_data,
  input logic                 word_valid,
  input logic                 word_ready,
  input logic                 overflow
);
  // R5: trigger is a single-clock pulse
  a_r5_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_trig |=> !tx_trig);

  // R6: recovered clock falls in the clock after the trigger
  a_r6_fclk_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
    tx_trig |=> $fell(fclk_out));

  // R4: pulse level only changes during the high half of the frame clock
  a_r4_pulse_in_high_half: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pulse_out) |-> fclk_out);

  // R9: a stalled word holds
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

  // R10: overflow is sticky
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind line_frame_rx lfr_checker #(.WORD_BITS(WORD_BITS)) u_lfr_checker (
  .clk(clk), .rst_n(rst_n), .pulse_out(pulse_out), .fclk_out(fclk_out),
  .tx_trig(tx_trig), .word_data(word_data), .word_valid(word_valid),
  .word_ready(word_ready), .overflow(overflow)
);

// File: tb/line_frame_rx_bench.sv
module line_frame_rx_bench;
  localparam int WB = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          line_in = 1'b0;
  logic          word_ready = 1'b1;
  logic          pulse_out, fclk_out, tx_trig, word_valid, overflow;
  logic [WB-1:0] word_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int trig_cnt = 0, trig_cyc = 0, rise_cyc = 0, fall_cyc = 0, got_n = 0;
  logic          fclk_prev = 1'b0;
  logic [WB-1:0] got_word = '0;

  always #2 clk = ~clk;

  line_frame_rx u_line_frame_rx (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .pulse_out(pulse_out),
    .fclk_out(fclk_out), .tx_trig(tx_trig), .word_data(word_data),
    .word_valid(word_valid), .word_ready(word_ready), .overflow(overflow)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tx_trig) begin trig_cyc = cyc; trig_cnt++; end
    if (fclk_out && !fclk_prev) rise_cyc = cyc;
    if (!fclk_out && fclk_prev) fall_cyc = cyc;
    fclk_prev = fclk_out;
    if (word_valid && word_ready) begin got_word = word_data; got_n++; end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Frame: idle, start, pulse, valid, data; 8 clocks per slot.
  task automatic send_frame(input logic p, input logic v, input logic d);
    int rise_at;
    int trig_before;
    trig_before = trig_cnt;
    line_in = 1'b0; repeat (8) @(negedge clk);
    line_in = 1'b1; rise_at = cyc; repeat (8) @(negedge clk);
    line_in = p; repeat (8) @(negedge clk);
    line_in = v; repeat (8) @(negedge clk);
    line_in = d; repeat (8) @(negedge clk);
    chk("R3 one trigger per frame", 64'(trig_cnt - trig_before), 64'd1);
    chk("R5 trigger offset", 64'(trig_cyc - rise_at), 64'd22);
    chk("R2/R6 fclk rise offset", 64'(rise_cyc - rise_at), 64'd3);
    chk("R6 fclk high length", 64'(fall_cyc - rise_cyc), 64'd20);
    chk("R4 pulse level", 64'(pulse_out), 64'(p));
  endtask

  task automatic send_bits(input logic [WB-1:0] w, input int nbits);
    for (int i = WB - 1; i >= WB - nbits; i--) send_frame(i[0], 1'b1, w[i]);
  endtask

  // {p, v, d, expected pulse_out}
  localparam int NV = 8;
  localparam logic [3:0] VEC [NV] = '{
    4'b1001, 4'b0000, 4'b1111, 4'b0010,
    4'b0110, 4'b1101, 4'b0100, 4'b1001
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual cycles=%0d expected below 100000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset pulse_out", 64'(pulse_out), 64'd0);
    chk("R1 reset fclk_out", 64'(fclk_out), 64'd0);
    chk("R1 reset tx_trig", 64'(tx_trig), 64'd0);
    chk("R1 reset word_valid", 64'(word_valid), 64'd0);
    chk("R1 reset overflow", 64'(overflow), 64'd0);

    // Vector walk: pulse tracking and trigger/clock timing, no word ends.
    n0 = got_n;
    for (int k = 0; k < NV; k++) begin
      send_frame(VEC[k][3], VEC[k][2], VEC[k][1]);
      chk("R4 vector pulse", 64'(pulse_out), 64'(VEC[k][0]));
    end
    chk("R8 no word from vector frames", 64'(got_n - n0), 64'd0);

    // Full word, MSB first.
    send_frame(1'b0, 1'b0, 1'b0);
    n0 = got_n;
    send_bits(30'h2ACB1234, WB);
    chk("R7 one word out", 64'(got_n - n0), 64'd1);
    chk("R7 word value", 64'(got_word), 64'h2ACB1234);

    // Partial word discarded by an invalid frame.
    n0 = got_n;
    send_bits(30'h3FFFFFFF, 10);
    send_frame(1'b1, 1'b0, 1'b0);
    chk("R8 partial word dropped", 64'(got_n - n0), 64'd0);
    send_bits(30'h15555AA5, WB);
    chk("R8 realigned word count", 64'(got_n - n0), 64'd1);
    chk("R8 realigned word value", 64'(got_word), 64'h15555AA5);

    // Back-pressure and overflow.
    word_ready = 1'b0;
    send_frame(1'b0, 1'b0, 1'b0);
    send_bits(30'h0F0F0F0F, WB);
    chk("R9 held valid", 64'(word_valid), 64'd1);
    chk("R9 held data", 64'(word_data), 64'h0F0F0F0F);
    chk("R10 no overflow yet", 64'(overflow), 64'd0);
    send_bits(30'h30303030, WB);
    chk("R10 overflow set", 64'(overflow), 64'd1);
    chk("R10 old word kept", 64'(word_data), 64'h0F0F0F0F);
    n0 = got_n;
    word_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 handshake count", 64'(got_n - n0), 64'd1);
    chk("R9 handshake word", 64'(got_word), 64'h0F0F0F0F);
    chk("R9 valid drops", 64'(word_valid), 64'd0);
    send_frame(1'b0, 1'b0, 1'b0);
    send_bits(30'h01234567, WB);
    chk("R10 overflow sticky", 64'(overflow), 64'd1);
    chk("R7 word after overflow", 64'(got_word), 64'h01234567);

    // Line held high: one detection only.
    n0 = trig_cnt;
    line_in = 1'b0; repeat (8) @(negedge clk);
    line_in = 1'b1; repeat (120) @(negedge clk);
    chk("R2 steady high single detection", 64'(trig_cnt - n0), 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule